// File: doc/BRIEF.md
# Buffered SPI Master Shift Engine

This block is the data path of a serial peripheral master. It holds one transmit word, one shift register and one receive word. The host writes a word into the transmit holding register, then asks for a frame with a one-cycle start pulse. When the engine accepts the request it moves the held word into the shift register and runs a frame of 1 to 32 bits, most significant or least significant bit first. The received bits are collected in the same shift register. At the end of the frame the word moves into the receive holding register, where the host reads it.

Data is always right-aligned: a frame of length L uses bits L-1 down to 0 of both words, whatever the bit order. The serial clock comes from a programmable divider of the system clock. It idles low, the outgoing bit changes on its falling edge and the incoming bit is sampled on its rising edge. An unread receive word holds back every later frame. If the host asks for a frame without writing a new transmit word, the engine sends whatever the shift register still holds, which is the word it received last.

Top module: `spi_buf_engine`

## Requirements
- R1: After reset, tx_empty is 1, rx_full is 0, busy is 0, sclk is 0 and mosi is 0.
- R2: len_m1 holds the frame length minus one (7, 15 and 31 select 8, 16 and 32 bits). Exactly len_m1+1 bits go out on mosi and come in from miso per frame. Transmit bits above len_m1 are never sent, and receive bits above len_m1 read as 0.
- R3: With lsb_first=0, the first bit on mosi is bit len_m1 of the transmit word, and the first bit taken from miso ends up in bit len_m1 of the receive word.
- R4: With lsb_first=1, the first bit on mosi is bit 0 of the transmit word, and the first bit taken from miso ends up in bit 0 of the receive word.
- R5: tx_empty reads 0 in the cycle after a write. It reads 1 in the cycle after a start is accepted, unless a write happens in that same cycle.
- R6: At the clock edge that ends a frame, rx_full becomes 1 and rd_data shows the received word. A rd_en pulse clears rx_full in the next cycle.
- R7: A start pulse while rx_full is 1 is ignored: busy stays 0, and tx_empty and rx_full keep their values.
- R8: A start accepted while tx_empty is 1 sends the word left in the shift register, which is the last received word masked to the current length. After reset that word is zero.
- R9: sclk is low whenever busy is 0. Each sclk phase lasts clk_div+1 system cycles, so busy stays high for exactly 2*(len_m1+1)*(clk_div+1) cycles. Incoming bits are sampled on the rising edge of sclk and mosi changes only on the falling edge.
- R10: A start pulse while busy is ignored. The running frame keeps its length, and a word written meanwhile stays in the transmit holding register for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| len_m1 | input | 5 | Frame length minus one |
| lsb_first | input | 1 | 1 sends and receives the least significant bit first |
| clk_div | input | 4 | Length of each sclk phase in system cycles, minus one |
| wr_en | input | 1 | Write wr_data into the transmit holding register |
| wr_data | input | 32 | Transmit word, right-aligned |
| start | input | 1 | Frame request pulse |
| rd_en | input | 1 | Host has read the receive word |
| rd_data | output | 32 | Receive word, right-aligned, upper bits zero |
| tx_empty | output | 1 | Transmit holding register has no pending word |
| rx_full | output | 1 | Receive holding register holds an unread word |
| busy | output | 1 | A frame is in progress |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the engine with DATA_W=32 and DIV_W=4. That allows the full 32-bit frame, together with the 8- and 16-bit lengths, and divider settings of 0, 1 and 3. The widest frame therefore takes 256 cycles, so the timing rule can be checked exactly at several clock ratios. A slave model in the bench returns words whose upper bits are set, which shows that receive data is masked to the frame length. A chain of frames run without host writes shows the echo path carrying a received word, masked to a new length, into the next frame.

// File: rtl/spi_eng_pkg.sv
// Package: types shared by the shift engine modules.
// Assumes: nothing beyond IEEE 1800-2017.
package spi_eng_pkg;

    // Bit order of a frame, as selected by the lsb_first pin.
    typedef enum logic {
        ORDER_MSB = 1'b0,
        ORDER_LSB = 1'b1
    } spi_order_e;

endpackage

// File: rtl/spi_clk_gen.sv
// Module: serial clock generator.
// Produces sclk from the system clock while run is high. Each phase lasts
// div+1 system cycles. One-cycle rise/fall strobes mark the system clock
// edge at which sclk goes high or low.
// Assumes: run falls at the same edge as the last falling sclk edge, so
// sclk is back low whenever run is low.
module spi_clk_gen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sclk_o,
    output logic             rise,
    output logic             fall
);

    logic [DIV_W-1:0] phase_cnt;
    logic             phase_end;

    // Marks the last system cycle of the current sclk phase.
    always_comb begin
        phase_end = run && (phase_cnt == div);
        rise      = phase_end && !sclk_o;
        fall      = phase_end && sclk_o;
    end

    // Counts out the phase length and toggles sclk at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_cnt <= '0;
            sclk_o    <= 1'b0;
        end else if (phase_end) begin
            phase_cnt <= '0;
            sclk_o    <= !sclk_o;
        end else begin
            phase_cnt <= phase_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spi_shift_core.sv
// Module: frame shift register and bit counter.
// On load it fills the shift register, either from the transmit word or by
// keeping its own contents (echo), masked to the frame length, and latches
// length and order. It samples miso on each rising sclk edge and shifts on
// each falling edge. done pulses, with the finished word on done_word, in
// the cycle whose edge ends the frame.
// Assumes: load only arrives while busy is low.
module spi_shift_core #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_tx,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic              lsb_first,
    input  logic              rise,
    input  logic              fall,
    input  logic              miso,
    output logic              busy,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] done_word
);
    import spi_eng_pkg::*;

    logic [DATA_W-1:0] shreg;
    logic [LEN_W-1:0]  len_q;
    spi_order_e        order_q;
    logic [LEN_W-1:0]  bit_cnt;
    logic              in_bit;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] mask_new;
    logic [DATA_W-1:0] shifted;

    // Builds a mask of ones over bits len..0.
    function automatic logic [DATA_W-1:0] len_mask(input logic [LEN_W-1:0] len);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = (i <= int'(len));
        end
        return m;
    endfunction

    // Masks for the latched and the incoming length.
    always_comb begin
        mask_q   = len_mask(len_q);
        mask_new = len_mask(len_m1);
    end

    // Computes the shift register value after one falling sclk edge.
    always_comb begin
        if (order_q == ORDER_LSB) begin
            shifted         = shreg >> 1;
            shifted[len_q]  = in_bit;
        end else begin
            shifted = ((shreg << 1) | {{(DATA_W-1){1'b0}}, in_bit}) & mask_q;
        end
    end

    // Flags the final shift and presents the outgoing bit.
    always_comb begin
        done      = busy && fall && (bit_cnt == len_q);
        done_word = shifted;
        if (!busy) begin
            mosi = 1'b0;
        end else if (order_q == ORDER_LSB) begin
            mosi = shreg[0];
        end else begin
            mosi = shreg[len_q];
        end
    end

    // Loads a frame, samples on rising edges, shifts on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            len_q   <= '0;
            order_q <= ORDER_MSB;
            bit_cnt <= '0;
            in_bit  <= 1'b0;
            busy    <= 1'b0;
        end else if (load) begin
            shreg   <= (load_tx ? tx_word : shreg) & mask_new;
            len_q   <= len_m1;
            order_q <= spi_order_e'(lsb_first);
            bit_cnt <= '0;
            busy    <= 1'b1;
        end else if (busy) begin
            if (rise) begin
                in_bit <= miso;
            end
            if (fall) begin
                shreg <= shifted;
                if (bit_cnt == len_q) begin
                    busy <= 1'b0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spi_buf_ctl.sv
// Module: transmit and receive holding registers with start admission.
// A start is accepted only when no frame runs and the receive register is
// free. On acceptance the pending transmit word, if any, is handed over. A
// finished frame fills the receive register until the host reads it.
// Assumes: done comes with the finished word in the same cycle.
module spi_buf_ctl #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              start,
    input  logic              busy,
    input  logic              done,
    input  logic [DATA_W-1:0] done_word,
    output logic              load,
    output logic              load_tx,
    output logic [DATA_W-1:0] tx_word,
    output logic              tx_empty,
    output logic              rx_full,
    output logic [DATA_W-1:0] rd_data
);

    logic tx_valid;

    // Decides whether the start request is taken this cycle.
    always_comb begin
        load     = start && !busy && !rx_full;
        load_tx  = tx_valid;
        tx_empty = !tx_valid;
    end

    // Holds the pending transmit word; a write beats a handover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_word  <= '0;
            tx_valid <= 1'b0;
        end else if (wr_en) begin
            tx_word  <= wr_data;
            tx_valid <= 1'b1;
        end else if (load) begin
            tx_valid <= 1'b0;
        end
    end

    // Captures the finished word and releases it on a host read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rx_full <= 1'b0;
        end else if (done) begin
            rd_data <= done_word;
            rx_full <= 1'b1;
        end else if (rd_en) begin
            rx_full <= 1'b0;
        end
    end

    // R5
    tx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tx_empty);

    // R6
    rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_full);

endmodule

// File: rtl/spi_buf_engine.sv
// Module: top of the buffered SPI master shift engine.
// Ties the holding registers, the shift core and the serial clock
// generator together. Fixed mode: sclk idles low, data changes on falling
// and is sampled on rising edges.
// Assumes: miso is stable around rising sclk edges.
module spi_buf_engine #(
    parameter int DATA_W = 32,
    parameter int DIV_W  = 4,
    localparam int LEN_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic              lsb_first,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              start,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);

    logic              load;
    logic              load_tx;
    logic [DATA_W-1:0] tx_word;
    logic              done;
    logic [DATA_W-1:0] done_word;
    logic              rise;
    logic              fall;

    spi_buf_ctl #(.DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .start     (start),
        .busy      (busy),
        .done      (done),
        .done_word (done_word),
        .load      (load),
        .load_tx   (load_tx),
        .tx_word   (tx_word),
        .tx_empty  (tx_empty),
        .rx_full   (rx_full),
        .rd_data   (rd_data)
    );

    spi_shift_core #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_tx   (load_tx),
        .tx_word   (tx_word),
        .len_m1    (len_m1),
        .lsb_first (lsb_first),
        .rise      (rise),
        .fall      (fall),
        .miso      (miso),
        .busy      (busy),
        .mosi      (mosi),
        .done      (done),
        .done_word (done_word)
    );

    spi_clk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .div    (clk_div),
        .sclk_o (sclk),
        .rise   (rise),
        .fall   (fall)
    );

    // R9
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    // R1
    mosi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mosi);

    // R7
    rx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |=> !$rose(busy));

    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy);

endmodule

// File: tb/tb_spi_buf_engine.sv
module tb_spi_buf_engine;
    localparam int DATA_W = 32;
    localparam int DIV_W  = 4;
    localparam int LEN_W  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [LEN_W-1:0]  len_m1 = '0;
    logic              lsb_first = 1'b0;
    logic [DIV_W-1:0]  clk_div = '0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              start = 1'b0;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              tx_empty, rx_full, busy, sclk, mosi;
    logic              miso;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    spi_buf_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .len_m1(len_m1), .lsb_first(lsb_first),
        .clk_div(clk_div), .wr_en(wr_en), .wr_data(wr_data), .start(start),
        .rd_en(rd_en), .rd_data(rd_data), .tx_empty(tx_empty),
        .rx_full(rx_full), .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    always #2 clk = !clk;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_of(input int len);
        logic [31:0] m = '0;
        for (int i = 0; i < len; i++) m[i] = 1'b1;
        return m;
    endfunction

    // Slave model: presents its word bit by bit, advancing on falling sclk.
    logic [31:0] s_word = '0;
    int          s_len = 8;
    bit          s_lsb = 1'b0;
    int          s_idx = 0;
    always_comb begin
        if (s_idx >= s_len) miso = 1'b0;
        else if (s_lsb)     miso = s_word[s_idx];
        else                miso = s_word[s_len-1-s_idx];
    end
    always @(negedge sclk) s_idx = s_idx + 1;

    // Captures mosi on rising sclk into a right-aligned word.
    logic [31:0] m_word = '0;
    int          m_cnt = 0;
    always @(posedge sclk) begin
        if (s_lsb) m_word[m_cnt] = mosi;
        else       m_word = {m_word[30:0], mosi};
        m_cnt = m_cnt + 1;
    end

    int busy_cyc = 0;
    always @(negedge clk) if (busy) busy_cyc++;

    // Scoreboard queues.
    logic [31:0] q_rx[$];
    logic [31:0] q_tx[$];
    int          q_cyc[$];
    logic        rx_prev = 1'b0;

    // Monitor: on each new receive word, compares against the queue head.
    always @(negedge clk) begin
        if (rx_full && !rx_prev) begin
            if (q_rx.size() == 0) begin
                check(1'b0, "R6 unexpected frame", rd_data, 32'h0);
            end else begin
                logic [31:0] erx, etx;
                int ecyc;
                erx = q_rx.pop_front();
                etx = q_tx.pop_front();
                ecyc = q_cyc.pop_front();
                // R2 R3 R4 R6: received word right-aligned and masked
                check(rd_data == erx, "R6 receive word", rd_data, erx);
                // R2 R3 R4 R8: bits sent on mosi
                check(m_word == etx, "R2 transmit bits", m_word, etx);
                // R9: frame duration
                check(busy_cyc == ecyc, "R9 frame cycles", busy_cyc, ecyc);
            end
        end
        rx_prev <= rx_full;
    end

    // Driver: sets up one frame, queues expectations, requests it.
    task automatic run_frame(input int len, input bit lsb, input int div,
                             input bit do_write, input logic [31:0] txw,
                             input logic [31:0] sw, input logic [31:0] exp_tx,
                             input bit do_read, input bit poke);
        @(negedge clk);
        len_m1 = LEN_W'(len - 1);
        lsb_first = lsb;
        clk_div = DIV_W'(div);
        if (do_write) begin
            wr_en = 1'b1; wr_data = txw;
            @(negedge clk);
            wr_en = 1'b0;
            // R5: write makes tx_empty low
            check(tx_empty == 1'b0, "R5 after write", tx_empty, 0);
        end
        s_word = sw; s_len = len; s_lsb = lsb; s_idx = 0;
        m_word = '0; m_cnt = 0; busy_cyc = 0;
        q_rx.push_back(sw & mask_of(len));
        q_tx.push_back(exp_tx);
        q_cyc.push_back(2 * len * (div + 1));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R5 start accepted", busy, 1);
        // R5: accepted start empties the transmit register
        check(tx_empty == 1'b1, "R5 handover", tx_empty, 1);
        if (poke) begin
            repeat (20) @(negedge clk);
            // R10: write and start during a running frame
            wr_en = 1'b1; wr_data = 32'hFFFF_FF5A; start = 1'b1;
            @(negedge clk);
            wr_en = 1'b0; start = 1'b0;
        end
        while (!rx_full) @(negedge clk);
        @(negedge clk);
        if (poke) begin
            check(tx_empty == 1'b0, "R10 word kept", tx_empty, 0);
        end
        if (do_read) begin
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
            check(rx_full == 1'b0, "R6 read clears", rx_full, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);
        check(rx_full == 1'b0, "R1 rx_full", rx_full, 0);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(sclk == 1'b0, "R1 sclk", sclk, 0);
        check(mosi == 1'b0, "R1 mosi", mosi, 0);

        // R3 R2: 8-bit MSB first, upper bits of both words set
        run_frame(8, 1'b0, 1, 1'b1, 32'hFFFF_FFA5, 32'h1234_563C, 32'hA5, 1'b1, 1'b0);
        // R4: 16-bit LSB first, fastest divider
        run_frame(16, 1'b1, 0, 1'b1, 32'h0000_C3A1, 32'h00A0_BEEF, 32'hC3A1, 1'b1, 1'b0);
        // R3 R10: 32-bit MSB first with mid-frame write and start
        run_frame(32, 1'b0, 3, 1'b1, 32'h8001_7FFE, 32'hDEAD_BEEF, 32'h8001_7FFE, 1'b0, 1'b1);

        // R7: start while the receive word is unread
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R7 busy stays low", busy, 0);
        check(tx_empty == 1'b0, "R7 tx kept", tx_empty, 0);
        check(rx_full == 1'b1, "R7 rx kept", rx_full, 1);
        check(rd_data == 32'hDEAD_BEEF, "R7 rx word kept", rd_data, 32'hDEAD_BEEF);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(rx_full == 1'b0, "R6 read clears", rx_full, 0);

        // R10: the word written mid-frame goes out next, masked to 8 bits
        run_frame(8, 1'b0, 1, 1'b0, 32'h0, 32'hFFFF_FFC6, 32'h5A, 1'b1, 1'b0);
        // R8: echo of 0xC6 in a 16-bit LSB-first frame
        run_frame(16, 1'b1, 1, 1'b0, 32'h0, 32'h0000_1357, 32'h0000_00C6, 1'b1, 1'b0);
        // R8: echo of 0x1357 in a 32-bit MSB-first frame
        run_frame(32, 1'b0, 0, 1'b0, 32'h0, 32'hCAFE_0001, 32'h0000_1357, 1'b1, 1'b0);

        repeat (5) @(negedge clk);
        check(q_rx.size() == 0, "R6 all frames seen", q_rx.size(), 0);
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done_flag) begin
            done_flag = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule